// File: doc/BRIEF.md
# Non-Coherent Write-Back Data Cache Controller

This block is a private data cache for one core of a multicore system in which the hardware keeps no coherence between caches. It sits between the core's load/store port and a shared word-wide memory port. Lines are allocated on load and store misses, stores mark a line dirty, and a dirty line goes back to memory only when it is replaced or when software asks for it. Nothing from other cores is ever observed, so software keeps shared data consistent with three commands addressed to one line. Discard drops the line without writing it. Clean copies a dirty line out and keeps it valid. Flush copies a dirty line out and then drops it.

The cache is direct-mapped, with a parameterised number of sets and 16-byte lines of four 32-bit words. A configurable address window is uncached: loads and stores to it reach memory as single word transfers and never allocate a line. Only one request is handled at a time. The request port drops its ready signal from acceptance until the response pulse, so commands and accesses complete strictly in the order they are issued.

Top module: `ncc_cache`

## Requirements
- R1: After reset, req_ready is 1, resp_valid and mem_req are 0, and every line is invalid, so the first load to any cacheable address is a miss.
- R2: A load or store that hits raises resp_valid one clock edge after the accepting edge and makes no memory transfer. A load returns the cached word on resp_rdata.
- R3: A load miss on a clean or invalid line reads the four words of the line from memory in ascending word order, starting at the line-aligned word address, and responds six edges after acceptance with the requested word.
- R4: Stores use write-allocate. A store miss fills the line (six edges) and then writes the word. A store hit updates the word and marks the line dirty, and memory is not written.
- R5: A miss on a dirty line first writes all four words of the old line to memory, ascending, and then fills. The response comes ten edges after acceptance. Words the core never modified are written too and overwrite memory.
- R6: Discard (op code 2) clears the valid bit of the addressed line when its tag matches, writes nothing to memory, and responds after one edge. The next load of that line refetches memory. A discard whose tag does not match leaves the line intact.
- R7: Clean (op code 3) on a valid, dirty, tag-matching line writes its four words to memory and clears the dirty bit. The line stays valid, and the response comes five edges after acceptance. On a clean, invalid or non-matching line it responds after one edge with no memory transfer.
- R8: Flush (op code 4) writes back a dirty matching line as Clean does (five edges) and then invalidates it. On a clean matching line it only invalidates (one edge). The next load misses.
- R9: A load (op code 0) or store (op code 1) whose byte address lies in [NC_LO, NC_HI] makes one memory transfer and responds two edges after acceptance. It allocates no line and leaves the line in the set it maps to unchanged.
- R10: A valid line keeps returning its cached value after memory is changed by another agent, until it is discarded or flushed.
- R11: req_ready stays low from the accepting edge until resp_valid rises. resp_valid is a single-cycle pulse, one per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when high with req_valid |
| req_op | input | 3 | 0 load, 1 store, 2 discard, 3 clean, 4 flush |
| req_addr | input | ADDR_W (12) | Byte address; the low two bits are ignored |
| req_wdata | input | DATA_W (32) | Store data |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | DATA_W (32) | Load result, valid with resp_valid on loads |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | ADDR_W-2 (10) | Word address |
| mem_wdata | output | DATA_W (32) | Write data |
| mem_ack | input | 1 | Memory completes the transfer this cycle |
| mem_rdata | input | DATA_W (32) | Read data, valid with mem_ack |

## Verification
Every result is tied to a fixed edge count from the accepting edge, given a memory that acknowledges in the same cycle. A hit, a quick command or a discard takes 1 edge, an uncached access 2, a dirty clean or flush 5, a clean miss or store miss 6, and a dirty miss 10. The bench applies each request at a falling edge and counts falling edges until resp_valid is seen, and it compares that count minus one with the expected number. While it counts, it also checks that req_ready stays low and counts the memory reads and writes. Memory contents are compared after the response, when every transfer of the request has landed.

// File: rtl/ncc_pkg.sv
package ncc_pkg;

  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_DROP  = 3'd2,
    OP_CLEAN = 3'd3,
    OP_FLUSH = 3'd4
  } cmd_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOOK,
    S_EVICT,
    S_FILL,
    S_UNC
  } st_e;

  function automatic logic in_window(input logic [31:0] a,
                                     input logic [31:0] lo,
                                     input logic [31:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

endpackage

// File: rtl/ncc_line_store.sv
module ncc_line_store #(
  parameter int SETS   = 8,
  parameter int WPL    = 4,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(SETS),
  localparam int OFF_W = $clog2(WPL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  input  logic [OFF_W-1:0]  word,
  output logic              rd_valid,
  output logic              rd_dirty,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              set_line,
  input  logic [TAG_W-1:0]  set_tag,
  input  logic              set_dirty,
  input  logic              clr_dirty,
  input  logic              clr_valid
);

  logic [SETS-1:0]   valid_q;
  logic [SETS-1:0]   dirty_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [DATA_W-1:0] data_q [SETS][WPL];

  assign rd_valid = valid_q[idx];
  assign rd_dirty = dirty_q[idx];
  assign rd_tag   = tag_q[idx];
  assign rd_data  = data_q[idx][word];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (set_line) begin
        valid_q[idx] <= 1'b1;
        dirty_q[idx] <= 1'b0;
      end
      if (set_dirty) dirty_q[idx] <= 1'b1;
      if (clr_dirty) dirty_q[idx] <= 1'b0;
      if (clr_valid) valid_q[idx] <= 1'b0;
    end
  end

  generate
    for (genvar s = 0; s < SETS; s++) begin : g_set
      always_ff @(posedge clk) begin
        if (!rst_n) tag_q[s] <= '0;
        else if (set_line && idx == IDX_W'(s)) tag_q[s] <= set_tag;
      end
      for (genvar w = 0; w < WPL; w++) begin : g_word
        always_ff @(posedge clk) begin
          if (wr_en && idx == IDX_W'(s) && word == OFF_W'(w))
            data_q[s][w] <= wr_data;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/ncc_ctrl.sv
module ncc_ctrl
  import ncc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int SETS   = 8,
  parameter int WPL    = 4,
  parameter int unsigned NC_LO = 32'hC00,
  parameter int unsigned NC_HI = 32'hFFF,
  localparam int IDX_W = $clog2(SETS),
  localparam int OFF_W = $clog2(WPL),
  localparam int WA_W  = ADDR_W - 2,
  localparam int TAG_W = WA_W - IDX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WA_W-1:0]   mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [IDX_W-1:0]  st_idx,
  output logic [OFF_W-1:0]  st_word,
  input  logic              rd_valid,
  input  logic              rd_dirty,
  input  logic [TAG_W-1:0]  rd_tag,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              set_line,
  output logic [TAG_W-1:0]  set_tag,
  output logic              set_dirty,
  output logic              clr_dirty,
  output logic              clr_valid
);

  function automatic logic [IDX_W-1:0] f_index(input logic [ADDR_W-1:0] a);
    return a[2+OFF_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [OFF_W-1:0] f_off(input logic [ADDR_W-1:0] a);
    return a[2 +: OFF_W];
  endfunction

  function automatic logic [WA_W-1:0] f_line_word(input logic [TAG_W-1:0] t,
                                                  input logic [IDX_W-1:0] i,
                                                  input logic [OFF_W-1:0] w);
    return {t, i, w};
  endfunction

  st_e               st_q, st_d;
  cmd_e              op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [OFF_W-1:0]  cnt_q, cnt_d;
  logic              resp_d;
  logic [DATA_W-1:0] rdata_d;

  logic [IDX_W-1:0]  idx_w;
  logic [TAG_W-1:0]  tag_w;
  logic [OFF_W-1:0]  off_w;
  logic              nc_w, hit_w, look_w, access_w, last_w;
  logic              evict_last, fill_last, wb_finish;

  assign idx_w    = f_index(addr_q);
  assign tag_w    = f_tag(addr_q);
  assign off_w    = f_off(addr_q);
  assign nc_w     = in_window(32'(addr_q), NC_LO, NC_HI);
  assign hit_w    = rd_valid && (rd_tag == tag_w);
  assign look_w   = (st_q == S_LOOK);
  assign access_w = (op_q == OP_LOAD) || (op_q == OP_STORE);
  assign last_w   = (cnt_q == OFF_W'(WPL - 1));
  assign evict_last = (st_q == S_EVICT) && mem_ack && last_w;
  assign fill_last  = (st_q == S_FILL) && mem_ack && last_w;
  assign wb_finish  = evict_last && !access_w;

  assign st_idx  = idx_w;
  assign set_tag = tag_w;

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    resp_d    = 1'b0;
    rdata_d   = resp_rdata;
    req_ready = (st_q == S_IDLE);
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = f_line_word(tag_w, idx_w, cnt_q);
    mem_wdata = rd_data;
    st_word   = off_w;
    wr_en     = 1'b0;
    wr_data   = wdata_q;
    set_line  = 1'b0;
    set_dirty = 1'b0;
    clr_dirty = 1'b0;
    clr_valid = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (req_valid) st_d = S_LOOK;
      end
      S_LOOK: begin
        cnt_d = '0;
        if (nc_w && access_w) begin
          st_d = S_UNC;
        end else begin
          unique case (op_q)
            OP_LOAD, OP_STORE: begin
              if (hit_w) begin
                resp_d  = 1'b1;
                rdata_d = rd_data;
                st_d    = S_IDLE;
                if (op_q == OP_STORE) begin
                  wr_en     = 1'b1;
                  set_dirty = 1'b1;
                end
              end else if (rd_valid && rd_dirty) begin
                st_d = S_EVICT;
              end else begin
                st_d = S_FILL;
              end
            end
            OP_CLEAN, OP_FLUSH: begin
              if (hit_w && rd_dirty) begin
                st_d = S_EVICT;
              end else begin
                clr_valid = hit_w && (op_q == OP_FLUSH);
                resp_d    = 1'b1;
                st_d      = S_IDLE;
              end
            end
            default: begin
              clr_valid = hit_w && (op_q == OP_DROP);
              resp_d    = 1'b1;
              st_d      = S_IDLE;
            end
          endcase
        end
      end
      S_EVICT: begin
        st_word  = cnt_q;
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = f_line_word(rd_tag, idx_w, cnt_q);
        if (mem_ack) begin
          cnt_d = cnt_q + 1'b1;
          if (last_w) begin
            if (access_w) begin
              st_d = S_FILL;
            end else begin
              clr_dirty = 1'b1;
              clr_valid = (op_q == OP_FLUSH);
              resp_d    = 1'b1;
              st_d      = S_IDLE;
            end
          end
        end
      end
      S_FILL: begin
        st_word = cnt_q;
        mem_req = 1'b1;
        if (mem_ack) begin
          wr_en   = 1'b1;
          wr_data = mem_rdata;
          cnt_d   = cnt_q + 1'b1;
          if (last_w) begin
            set_line = 1'b1;
            st_d     = S_LOOK;
          end
        end
      end
      S_UNC: begin
        mem_req   = 1'b1;
        mem_we    = (op_q == OP_STORE);
        mem_addr  = addr_q[ADDR_W-1:2];
        mem_wdata = wdata_q;
        if (mem_ack) begin
          resp_d  = 1'b1;
          rdata_d = mem_rdata;
          st_d    = S_IDLE;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      op_q       <= OP_LOAD;
      addr_q     <= '0;
      wdata_q    <= '0;
      cnt_q      <= '0;
      resp_valid <= 1'b0;
      resp_rdata <= '0;
    end else begin
      st_q       <= st_d;
      cnt_q      <= cnt_d;
      resp_valid <= resp_d;
      resp_rdata <= rdata_d;
      if (req_valid && req_ready) begin
        op_q    <= cmd_e'(req_op);
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
    end
  end

  assert_hit_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (look_w && hit_w && access_w && !nc_w) |=> (resp_valid && !mem_req));

  assert_fill_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == S_FILL) && mem_ack && !fill_last) |=>
      (mem_addr == WA_W'($past(mem_addr) + 1'b1)));

  assert_drop_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (look_w && (op_q == OP_DROP) && hit_w) |=> (!rd_valid && !mem_req));

  assert_clean_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_finish |=> !rd_dirty);

  assert_flush_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_finish && (op_q == OP_FLUSH)) |=> !rd_valid);

  assert_no_alloc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    set_line |-> !nc_w);

  assert_resp_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  assert_busy_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

endmodule

// File: rtl/ncc_cache.sv
module ncc_cache #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int SETS   = 8,
  parameter int WPL    = 4,
  parameter int unsigned NC_LO = 32'hC00,
  parameter int unsigned NC_HI = 32'hFFF,
  localparam int IDX_W = $clog2(SETS),
  localparam int OFF_W = $clog2(WPL),
  localparam int WA_W  = ADDR_W - 2,
  localparam int TAG_W = WA_W - IDX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WA_W-1:0]   mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);

  logic [IDX_W-1:0]  st_idx;
  logic [OFF_W-1:0]  st_word;
  logic              rd_valid, rd_dirty;
  logic [TAG_W-1:0]  rd_tag, set_tag;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic              wr_en, set_line, set_dirty, clr_dirty, clr_valid;

  ncc_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS), .WPL(WPL),
    .NC_LO(NC_LO), .NC_HI(NC_HI)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .st_idx(st_idx), .st_word(st_word),
    .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag), .rd_data(rd_data),
    .wr_en(wr_en), .wr_data(wr_data), .set_line(set_line), .set_tag(set_tag),
    .set_dirty(set_dirty), .clr_dirty(clr_dirty), .clr_valid(clr_valid)
  );

  ncc_line_store #(
    .SETS(SETS), .WPL(WPL), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .idx(st_idx), .word(st_word),
    .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag), .rd_data(rd_data),
    .wr_en(wr_en), .wr_data(wr_data), .set_line(set_line), .set_tag(set_tag),
    .set_dirty(set_dirty), .clr_dirty(clr_dirty), .clr_valid(clr_valid)
  );

endmodule

// File: tb/tb_ncc_cache.sv
`timescale 1ns/1ps
module tb_ncc_cache;

  localparam logic [2:0] LD = 3'd0, ST = 3'd1, DROP = 3'd2, CLN = 3'd3, FLS = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = '0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        resp_valid;
  logic [31:0] resp_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [9:0]  mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  logic [31:0] mem [0:1023];
  int          rd_cnt = 0, wr_cnt = 0;
  logic        bd_en = 1'b0;
  logic [9:0]  bd_addr = '0;
  logic [31:0] bd_data = '0;
  int          checks = 0, errors = 0;

  always #5 clk = ~clk;

  ncc_cache dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] pat(input int w);
    return 32'(w) * 32'h0001_0003 + 32'h0000_1234;
  endfunction

  function automatic logic [11:0] ba(input int t, input int s, input int w);
    return {5'(t), 3'(s), 2'(w), 2'b00};
  endfunction

  function automatic int wa(input int t, input int s, input int w);
    return int'(ba(t, s, w) >> 2);
  endfunction

  assign mem_ack   = mem_req;
  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) mem[i] <= pat(i);
    end else begin
      if (mem_req && mem_ack) begin
        if (mem_we) begin
          mem[mem_addr] <= mem_wdata;
          wr_cnt <= wr_cnt + 1;
        end else begin
          rd_cnt <= rd_cnt + 1;
        end
      end
      if (bd_en) mem[bd_addr] <= bd_data;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic backdoor(input int w, input logic [31:0] d);
    @(negedge clk);
    bd_en = 1'b1; bd_addr = 10'(w); bd_data = d;
    @(negedge clk);
    bd_en = 1'b0;
  endtask

  // Issues one request, returns data, edge count from acceptance, transfers.
  task automatic run(input logic [2:0] op, input logic [11:0] a, input logic [31:0] d,
                     output logic [31:0] q, output int lat, output int nrd,
                     output int nwr);
    int  rd0, wr0, cyc;
    bit  busy_ok;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
    rd0 = rd_cnt; wr0 = wr_cnt;
    chk(req_ready == 1'b1, "R11 ready before issue", 32'(req_ready), 32'd1);
    @(posedge clk);
    cyc = 0; busy_ok = 1'b1;
    forever begin
      @(negedge clk);
      req_valid = 1'b0;
      cyc++;
      if (resp_valid) break;
      if (req_ready) busy_ok = 1'b0;
      if (cyc > 40) break;
    end
    lat = cyc - 1; q = resp_rdata; nrd = rd_cnt - rd0; nwr = wr_cnt - wr0;
    chk(busy_ok, "R11 ready low while busy", 32'(busy_ok), 32'd1);
    @(negedge clk);
    chk(!resp_valid, "R11 single response pulse", 32'(resp_valid), 32'd0);
  endtask

  task automatic expect_op(input logic [2:0] op, input logic [11:0] a,
                           input logic [31:0] d, input bit chk_q,
                           input logic [31:0] exp_q, input int exp_lat,
                           input int exp_rd, input int exp_wr, input string tag);
    logic [31:0] q;
    int lat, nrd, nwr;
    run(op, a, d, q, lat, nrd, nwr);
    chk(lat == exp_lat, {tag, " latency"}, 32'(lat), 32'(exp_lat));
    chk(nrd == exp_rd, {tag, " memory reads"}, 32'(nrd), 32'(exp_rd));
    chk(nwr == exp_wr, {tag, " memory writes"}, 32'(nwr), 32'(exp_wr));
    if (chk_q) chk(q == exp_q, {tag, " data"}, q, exp_q);
  endtask

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready in reset", 32'(req_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
    chk(resp_valid == 1'b0, "R1 no response after reset", 32'(resp_valid), 32'd0);
    chk(mem_req == 1'b0, "R1 memory idle after reset", 32'(mem_req), 32'd0);

    // R1/R3/R2: sweep every word of tag 0; first word misses, others hit.
    for (int s = 0; s < 8; s++)
      for (int w = 0; w < 4; w++)
        if (w == 0) expect_op(LD, ba(0, s, w), 0, 1, pat(wa(0, s, w)), 6, 4, 0, "R1 R3 cold miss");
        else        expect_op(LD, ba(0, s, w), 0, 1, pat(wa(0, s, w)), 1, 0, 0, "R2 load hit");

    // R4: store hits mark dirty, memory unchanged.
    for (int s = 0; s < 8; s++) begin
      expect_op(ST, ba(0, s, 0), 32'hD000_0000 | 32'(s), 0, 0, 1, 0, 0, "R4 store hit");
      expect_op(LD, ba(0, s, 0), 0, 1, 32'hD000_0000 | 32'(s), 1, 0, 0, "R4 read back");
      chk(mem[wa(0, s, 0)] == pat(wa(0, s, 0)), "R4 memory untouched", mem[wa(0, s, 0)], pat(wa(0, s, 0)));
    end

    // R5: dirty eviction writes whole line, then fills.
    for (int s = 0; s < 4; s++) begin
      expect_op(LD, ba(1, s, 2), 0, 1, pat(wa(1, s, 2)), 10, 4, 4, "R5 dirty miss");
      chk(mem[wa(0, s, 0)] == (32'hD000_0000 | 32'(s)), "R5 stored word written", mem[wa(0, s, 0)], 32'hD000_0000 | 32'(s));
      for (int w = 1; w < 4; w++)
        chk(mem[wa(0, s, w)] == pat(wa(0, s, w)), "R5 rest of line written", mem[wa(0, s, w)], pat(wa(0, s, w)));
    end

    // R4: store miss allocates.
    expect_op(ST, ba(2, 0, 1), 32'h5A5A_0001, 0, 0, 6, 4, 0, "R4 store miss allocate");
    expect_op(LD, ba(2, 0, 1), 0, 1, 32'h5A5A_0001, 1, 0, 0, "R4 allocated line hit");
    expect_op(LD, ba(2, 0, 3), 0, 1, pat(wa(2, 0, 3)), 1, 0, 0, "R4 filled neighbour");

    // R10/R6: stale data until discard.
    backdoor(wa(1, 1, 2), 32'hBAD0_0001);
    expect_op(LD, ba(1, 1, 2), 0, 1, pat(wa(1, 1, 2)), 1, 0, 0, "R10 stale value kept");
    expect_op(DROP, ba(1, 1, 2), 0, 0, 0, 1, 0, 0, "R6 discard");
    expect_op(LD, ba(1, 1, 2), 0, 1, 32'hBAD0_0001, 6, 4, 0, "R6 refetch after discard");
    expect_op(DROP, ba(3, 1, 0), 0, 0, 0, 1, 0, 0, "R6 discard tag mismatch");
    expect_op(LD, ba(1, 1, 2), 0, 1, 32'hBAD0_0001, 1, 0, 0, "R6 mismatch leaves line");

    // R7: clean keeps line valid and clears dirty.
    expect_op(CLN, ba(2, 0, 0), 0, 0, 0, 5, 0, 4, "R7 clean dirty line");
    chk(mem[wa(2, 0, 1)] == 32'h5A5A_0001, "R7 cleaned word in memory", mem[wa(2, 0, 1)], 32'h5A5A_0001);
    expect_op(LD, ba(2, 0, 1), 0, 1, 32'h5A5A_0001, 1, 0, 0, "R7 line still valid");
    expect_op(CLN, ba(2, 0, 0), 0, 0, 0, 1, 0, 0, "R7 second clean quick");
    expect_op(CLN, ba(5, 0, 0), 0, 0, 0, 1, 0, 0, "R7 clean mismatch quick");

    // R8: flush dirty and clean lines.
    expect_op(ST, ba(1, 2, 3), 32'hF1F1_0003, 0, 0, 1, 0, 0, "R8 store before flush");
    expect_op(FLS, ba(1, 2, 3), 0, 0, 0, 5, 0, 4, "R8 flush dirty");
    chk(mem[wa(1, 2, 3)] == 32'hF1F1_0003, "R8 flushed word in memory", mem[wa(1, 2, 3)], 32'hF1F1_0003);
    expect_op(LD, ba(1, 2, 3), 0, 1, 32'hF1F1_0003, 6, 4, 0, "R8 miss after flush");
    expect_op(FLS, ba(1, 2, 0), 0, 0, 0, 1, 0, 0, "R8 flush clean");
    expect_op(LD, ba(1, 2, 0), 0, 1, pat(wa(1, 2, 0)), 6, 4, 0, "R8 miss after clean flush");

    // R5: whole-line write-back overwrites another agent's update.
    backdoor(wa(1, 3, 1), 32'hEEEE_0001);
    expect_op(ST, ba(1, 3, 0), 32'h5555_0000, 0, 0, 1, 0, 0, "R5 store to shared line");
    expect_op(FLS, ba(1, 3, 0), 0, 0, 0, 5, 0, 4, "R5 flush shared line");
    chk(mem[wa(1, 3, 1)] == pat(wa(1, 3, 1)), "R5 unmodified word overwrites memory", mem[wa(1, 3, 1)], pat(wa(1, 3, 1)));
    chk(mem[wa(1, 3, 0)] == 32'h5555_0000, "R5 modified word in memory", mem[wa(1, 3, 0)], 32'h5555_0000);

    // R9: uncached window.
    expect_op(LD, ba(26, 5, 2), 0, 1, pat(wa(26, 5, 2)), 2, 1, 0, "R9 uncached load");
    expect_op(ST, ba(26, 5, 2), 32'h0000_0077, 0, 0, 2, 0, 1, "R9 uncached store");
    chk(mem[wa(26, 5, 2)] == 32'h77, "R9 uncached store reaches memory", mem[wa(26, 5, 2)], 32'h77);
    expect_op(LD, ba(26, 5, 2), 0, 1, 32'h77, 2, 1, 0, "R9 no allocation");
    expect_op(LD, ba(0, 5, 0), 0, 1, 32'hD000_0005, 1, 0, 0, "R9 cached line unchanged");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule